// File: doc/BRIEF.md
# Clocked Serial Memory Streamer

This block reads out a small byte memory one bit at a time, paced by a slow transmit clock that is separate from the system clock. After reset it waits through a fixed number of transmit-clock edges with the data line released. It then sends every byte in ascending address order, most significant bit first, and follows each byte with one extra bit slot in which the line stays released. When the last location has been sent, the address returns to zero and streaming goes on without a break. The first byte sent is the one at an address loaded during reset.

The data line is shared with a two-wire bus slave that lives outside this block. The bus clock line idles high. The first falling edge seen on it sets a sticky mode flag. The flag hands the line over: the output enable drops, and transmit-clock edges have no further effect. Only a reset clears the flag. Both raw clock lines are brought into the system clock domain through synchroniser chains, and edges are detected on the synchronised values. The memory has a plain synchronous read port: the address is presented and the data comes back one system clock later.

Top module: `ser_mem_streamer`

## Requirements
- R1: While reset is held and after it is released, `data_oe` is 0, `data_out` is 1, and `bidir_mode` is 0 until something happens on a clock line.
- R2: During the first WARM_EDGES (default 9) rising edges of `tx_clk_in` after reset, `data_oe` stays 0.
- R3: On the next rising edge (the tenth by default), `data_oe` goes to 1 and `data_out` carries bit 7 of the byte at the start address.
- R4: On each of the seven rising edges that follow, `data_out` carries the next lower bit of the byte, down to bit 0. Between edges, `data_out` does not change.
- R5: The ninth edge of every byte frame is a null slot: `data_oe` is 0 and `data_out` is 1. Whenever `data_oe` is 0, `data_out` is 1.
- R6: After each null slot, `mem_addr` moves up by exactly one, and it goes from 127 to 0 at the top of the address range. Streaming then continues with that byte.
- R7: `start_addr` is sampled while reset is held. It sets both `mem_addr` and the first byte streamed.
- R8: A falling edge on `bus_clk_in` sets `bidir_mode` to 1 and drops `data_oe` on the same clock. After that, rising edges on `tx_clk_in` change neither `data_oe` nor `mem_addr`.
- R9: Once `bidir_mode` is 1 it stays 1, even when `bus_clk_in` goes high or falls again. Only reset returns it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample both clock lines |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_clk_in | input | 1 | Raw transmit clock; each rising edge advances one bit |
| bus_clk_in | input | 1 | Raw bus clock; idles high, and its falling edge hands over the line |
| start_addr | input | ADDR_W | Byte address loaded during reset |
| mem_addr | output | ADDR_W | Read address to the memory |
| mem_rdata | input | DATA_W | Read data, valid one clock after `mem_addr` |
| data_out | output | 1 | Serial data value; 1 when released |
| data_oe | output | 1 | Drive enable for the shared data line |
| bidir_mode | output | 1 | Sticky flag that shows the line belongs to the bus slave |

## Verification
A miscounted warm-up counter shows within one transmit clock: either the line is driven too early, or the first driven bit is not bit 7 of the start byte. A bit index that slips shows as a wrong bit value or a missing null slot within one nine-edge frame. A broken address step shows on `mem_addr` at the null slot, and most clearly at the 127 to 0 wrap. A mode flag that does not latch, or that clears, shows a few system clocks after a bus-clock fall: `data_oe` comes back, or `bidir_mode` drops, while transmit edges keep arriving.

// File: rtl/smst_pkg.sv
package smst_pkg;
   // Sequencer phase: hold the line released while counting, then stream.
   typedef enum logic {
      PH_WARMUP = 1'b0,
      PH_STREAM = 1'b1
   } smst_phase_t;
endpackage

// File: rtl/smst_sync.sv
module smst_sync #(
   parameter int unsigned STAGES    = 2,
   parameter bit          RESET_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_raw,
   output logic q_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("smst_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            chain_q[i] <= RESET_VAL;
         end else begin
            if (i == 0) chain_q[i] <= d_raw;
            else        chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
         end
      end
   end

   assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/smst_mode_latch.sv
module smst_mode_latch #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_clk_raw,
   output logic bus_fall,
   output logic mode_q
);
   logic bus_s;
   logic bus_d;

   // Idle level of the bus clock is high, so a reset value of 1 gives no false edge.
   smst_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_bus_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_raw  (bus_clk_raw),
      .q_sync (bus_s)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_d  <= 1'b1;
         mode_q <= 1'b0;
      end else begin
         bus_d <= bus_s;
         if (bus_fall) mode_q <= 1'b1;
      end
   end

   assign bus_fall = bus_d & ~bus_s;
endmodule

// File: rtl/smst_sequencer.sv
module smst_sequencer
   import smst_pkg::*;
#(
   parameter int unsigned ADDR_W     = 7,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned WARM_EDGES = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic [ADDR_W-1:0] start_addr,
   input  logic [DATA_W-1:0] rdata,
   output logic [ADDR_W-1:0] addr_q,
   output logic              bit_q,
   output logic              drive_q
);
   localparam int unsigned BIT_W  = $clog2(DATA_W + 1);
   localparam int unsigned WARM_W = $clog2(WARM_EDGES + 1);
   localparam logic [BIT_W-1:0]  NULL_SLOT = BIT_W'(DATA_W);
   localparam logic [WARM_W-1:0] WARM_LAST = WARM_W'(WARM_EDGES - 1);

   if (WARM_EDGES < 1) begin : g_bad_warm
      $error("smst_sequencer: WARM_EDGES must be at least 1");
   end
   if (DATA_W < 2) begin : g_bad_width
      $error("smst_sequencer: DATA_W must be at least 2");
   end

   smst_phase_t       phase_q;
   logic [WARM_W-1:0] warm_q;
   logic [BIT_W-1:0]  slot_q;
   logic [DATA_W-1:0] shift_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_WARMUP;
         warm_q  <= '0;
         slot_q  <= '0;
         shift_q <= '0;
         addr_q  <= start_addr;
         bit_q   <= 1'b1;
         drive_q <= 1'b0;
      end else if (step) begin
         if (phase_q == PH_WARMUP) begin
            warm_q <= warm_q + 1'b1;
            if (warm_q == WARM_LAST) phase_q <= PH_STREAM;
         end else if (slot_q == '0) begin
            bit_q   <= rdata[DATA_W-1];
            shift_q <= {rdata[DATA_W-2:0], 1'b0};
            drive_q <= 1'b1;
            slot_q  <= slot_q + 1'b1;
         end else if (slot_q == NULL_SLOT) begin
            bit_q   <= 1'b1;
            drive_q <= 1'b0;
            slot_q  <= '0;
            addr_q  <= addr_q + 1'b1;
         end else begin
            bit_q   <= shift_q[DATA_W-1];
            shift_q <= {shift_q[DATA_W-2:0], 1'b0};
            slot_q  <= slot_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/ser_mem_streamer.sv
module ser_mem_streamer #(
   parameter int unsigned ADDR_W      = 7,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned WARM_EDGES  = 9,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_clk_in,
   input  logic              bus_clk_in,
   input  logic [ADDR_W-1:0] start_addr,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              data_out,
   output logic              data_oe,
   output logic              bidir_mode
);
   logic tx_s;
   logic tx_d;
   logic tx_rise;
   logic bus_fall;
   logic mode_q;
   logic bit_q;
   logic drive_q;

   smst_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_tx_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_raw  (tx_clk_in),
      .q_sync (tx_s)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) tx_d <= 1'b0;
      else        tx_d <= tx_s;
   end

   assign tx_rise = tx_s & ~tx_d;

   smst_mode_latch #(.SYNC_STAGES(SYNC_STAGES)) u_mode (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_clk_raw (bus_clk_in),
      .bus_fall    (bus_fall),
      .mode_q      (mode_q)
   );

   smst_sequencer #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .WARM_EDGES (WARM_EDGES)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .step       (tx_rise & ~mode_q),
      .start_addr (start_addr),
      .rdata      (mem_rdata),
      .addr_q     (mem_addr),
      .bit_q      (bit_q),
      .drive_q    (drive_q)
   );

   assign data_oe    = drive_q & ~mode_q;
   assign data_out   = bit_q | mode_q;
   assign bidir_mode = mode_q;
endmodule

// File: rtl/smst_checker.sv
module smst_checker #(
   parameter int unsigned ADDR_W = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tx_rise,
   input logic              bus_fall,
   input logic              data_out,
   input logic              data_oe,
   input logic              bidir_mode,
   input logic [ADDR_W-1:0] mem_addr
);
   logic run_q;
   always_ff @(posedge clk) begin
      if (!rst_n) run_q <= 1'b0;
      else        run_q <= 1'b1;
   end

   p_quiet_between_edges_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !tx_rise && !bus_fall) |=> $stable(data_out));

   p_released_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !data_oe |-> data_out);

   p_addr_single_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !$stable(mem_addr)) |-> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

   p_fall_hands_over_r8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_fall |=> (bidir_mode && !data_oe));

   p_mode_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      bidir_mode |=> bidir_mode);
endmodule

bind ser_mem_streamer smst_checker #(.ADDR_W(ADDR_W)) u_smst_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .tx_rise    (tx_rise),
   .bus_fall   (bus_fall),
   .data_out   (data_out),
   .data_oe    (data_oe),
   .bidir_mode (bidir_mode),
   .mem_addr   (mem_addr)
);

// File: tb/ser_mem_streamer_bench.sv
module ser_mem_streamer_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tx_clk_in = 1'b0;
   logic       bus_clk_in = 1'b1;
   logic [6:0] start_addr = '0;
   logic [6:0] mem_addr;
   logic [7:0] mem_rdata;
   logic       data_out;
   logic       data_oe;
   logic       bidir_mode;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   ser_mem_streamer u_ser_mem_streamer (
      .clk        (clk),
      .rst_n      (rst_n),
      .tx_clk_in  (tx_clk_in),
      .bus_clk_in (bus_clk_in),
      .start_addr (start_addr),
      .mem_addr   (mem_addr),
      .mem_rdata  (mem_rdata),
      .data_out   (data_out),
      .data_oe    (data_oe),
      .bidir_mode (bidir_mode)
   );

   function automatic logic [7:0] mem_val(input logic [6:0] a);
      return 8'({1'b0, a} * 8'd37) ^ 8'hA5;
   endfunction

   always_ff @(posedge clk) mem_rdata <= mem_val(mem_addr);

   // Vector: {start address, expected address after the first byte}
   localparam logic [13:0] VEC [5] = '{
      {7'd0,   7'd1},
      {7'd5,   7'd6},
      {7'd63,  7'd64},
      {7'd126, 7'd127},
      {7'd127, 7'd0}
   };

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset(input logic [6:0] a);
      @(negedge clk);
      rst_n = 1'b0; tx_clk_in = 1'b0; bus_clk_in = 1'b1; start_addr = a;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   // One transmit clock period; outputs sampled well after the rising edge.
   task automatic tx_pulse(output logic so, output logic sd);
      tx_clk_in = 1'b1;
      repeat (6) @(negedge clk);
      so = data_oe; sd = data_out;
      tx_clk_in = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      summary();
   end

   initial begin
      logic so, sd;
      logic [6:0] a, nxt;
      logic [7:0] b;

      // R1: reset state, sampled while reset is held and after release
      @(negedge clk); @(negedge clk);
      check(!data_oe && data_out && !bidir_mode, "R1 in reset",
            {data_oe, data_out, bidir_mode}, 3'b010);
      do_reset(7'd0);
      check(!data_oe && data_out && !bidir_mode, "R1 after release",
            {data_oe, data_out, bidir_mode}, 3'b010);

      // Table walk: warm-up, two full frames and the address step per vector
      for (int v = 0; v < 5; v++) begin
         a   = VEC[v][13:7];
         nxt = VEC[v][6:0];
         do_reset(a);
         check(mem_addr == a, "R7 start address", mem_addr, a);
         for (int w = 0; w < 9; w++) begin
            tx_pulse(so, sd);
            check(!so && sd, "R2 warm-up released", {so, sd}, 2'b01);
         end
         for (int f = 0; f < 2; f++) begin
            b = mem_val(a);
            for (int k = 7; k >= 0; k--) begin
               tx_pulse(so, sd);
               if (f == 0 && k == 7)
                  check(so && sd == b[7], "R3 first bit is MSB", {so, sd}, {1'b1, b[7]});
               else
                  check(so && sd == b[k], "R4 bit order", {so, sd}, {1'b1, b[k]});
            end
            tx_pulse(so, sd);
            check(!so && sd, "R5 null slot", {so, sd}, 2'b01);
            if (f == 0) check(mem_addr == nxt, "R6 address step/wrap", mem_addr, nxt);
            a = a + 7'd1;
         end
      end

      // R8: hand-over in the middle of a byte, then transmit edges are ignored
      do_reset(7'd10);
      for (int w = 0; w < 12; w++) tx_pulse(so, sd);
      check(data_oe == 1'b1, "R8 driving before hand-over", data_oe, 1);
      bus_clk_in = 1'b0;
      repeat (6) @(negedge clk);
      check(bidir_mode && !data_oe && data_out, "R8 hand-over",
            {bidir_mode, data_oe, data_out}, 3'b101);
      for (int w = 0; w < 10; w++) begin
         tx_pulse(so, sd);
         check(!so, "R8 tx edge ignored (oe)", so, 0);
      end
      check(mem_addr == 7'd10, "R8 tx edge ignored (addr)", mem_addr, 10);

      // R9: flag stays set through more bus clock activity, reset clears it
      bus_clk_in = 1'b1;
      repeat (6) @(negedge clk);
      check(bidir_mode, "R9 sticky after bus high", bidir_mode, 1);
      bus_clk_in = 1'b0;
      repeat (6) @(negedge clk);
      check(bidir_mode, "R9 sticky after second fall", bidir_mode, 1);
      do_reset(7'd3);
      check(!bidir_mode, "R9 cleared by reset", bidir_mode, 0);

      // R8: hand-over during warm-up keeps the line released afterwards
      for (int w = 0; w < 4; w++) tx_pulse(so, sd);
      bus_clk_in = 1'b0;
      repeat (6) @(negedge clk);
      for (int w = 0; w < 8; w++) tx_pulse(so, sd);
      check(!data_oe && bidir_mode && mem_addr == 7'd3, "R8 switch in warm-up",
            {data_oe, bidir_mode, mem_addr}, {2'b01, 7'd3});

      summary();
   end
endmodule